// File: doc/BRIEF.md
# Undercarriage Bay Door Sequencer

This block sits between a pilot gear lever and the actuators of one undercarriage bay. It drives the door open and door close actuators and the gear extend and retract actuators. Its inputs are the lever, two gear lock sensors (locked up, locked down) and two door lock sensors (locked open, locked closed). A gear that is in neither lock is taken to be moving. Each sensor and the lever pass through a short synchronizer. The block then keeps its own model of the door, which it exposes as a small state code.

A stroke always runs in the same order. The door opens first. The gear moves only once the door is confirmed locked open. The door closes again once the gear reports the lock it was sent to. Door commands are gated on the gear sitting in a lock. After reset the lever is ignored until one of the door lock sensors resolves the door position. A lever change made during a stroke never reverses the gear: the lever level is looked at again once the door has closed. A sticky fault output records any cycle in which the gear is out of both locks while the door is not locked open.

Top module: `bay_door_ctrl`

## Requirements
- R1: After reset `door_state` is 0 (unknown), every command output is 0 and `fault` is 0; while the door state is unknown no lever position raises any command.
- R2: The door state code is 0 unknown, 1 locked closed, 2 opening, 3 locked open, 4 closing; from unknown the locked-closed sensor gives 1 and the locked-open sensor gives 3.
- R3: In an idle bay with the door resolved and the gear locked, a lever level (`lever_ext` 1 = extend toward locked down, 0 = retract toward locked up) that differs from the gear's lock raises `door_open_cmd` and moves the state to 2; gear commands stay 0.
- R4: A gear command (`gear_ext_cmd` for extend, `gear_ret_cmd` for retract, never both) is raised only once the locked-open sensor is seen, together with state 3 and the drop of `door_open_cmd`. It is held until the matching gear lock sensor asserts.
- R5: When the target gear lock asserts, the gear command drops and `door_close_cmd` rises with state 4; the close command is held until the locked-closed sensor, which gives state 1 and drops it.
- R6: Door open or close commands are issued only while a gear lock sensor is active; with the gear out of both locks in an idle bay, no door command is raised.
- R7: A lever change during gear motion does not alter or reverse the gear command; once the door has closed, a lever level that differs from the gear's lock starts a new stroke one cycle later.
- R8: Once the door state is resolved, any cycle with neither gear lock active and the door not locked open (state 3 with the sensor present) sets `fault`, which stays set until reset.
- R9: Every output reacts to an input change on the third rising clock edge after it (two synchronizer stages plus one state register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lever_ext | input | 1 | Lever level: 1 extend, 0 retract |
| gear_up_lk | input | 1 | Gear locked up sensor |
| gear_dn_lk | input | 1 | Gear locked down sensor |
| door_open_lk | input | 1 | Door locked open sensor |
| door_shut_lk | input | 1 | Door locked closed sensor |
| door_open_cmd | output | 1 | Open-door actuator command |
| door_close_cmd | output | 1 | Close-door actuator command |
| gear_ext_cmd | output | 1 | Gear extend actuator command |
| gear_ret_cmd | output | 1 | Gear retract actuator command |
| door_state | output | 3 | Door model state code (see R2) |
| fault | output | 1 | Sticky safety fault |

## Verification
Every sensor or lever change reaches the outputs on the third rising edge. Pending strokes are the one exception: they start on the fourth edge after the locked-closed sensor, one cycle after the bay turns idle. The bench drives inputs on falling edges and advances a fixed number of falling edges before each comparison. In several places it checks the cycle before a response is due as well as the cycle it is due, so that any added or missing register stage is caught. Waiting phases, such as the door not yet locked open or the door mid-close, are checked several cycles in to show that commands are held and no gear command appears early.

// File: rtl/bay_door_pkg.sv
package bay_door_pkg;

    typedef enum logic [2:0] {
        DS_UNKNOWN = 3'd0,
        DS_SHUT    = 3'd1,
        DS_OPENING = 3'd2,
        DS_OPEN    = 3'd3,
        DS_CLOSING = 3'd4
    } door_st_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_OPEN,
        PH_MOVE,
        PH_CLOSE
    } phase_e;

    localparam int SENSE_W   = 5;
    localparam int IX_LEVER  = 4;
    localparam int IX_UP     = 3;
    localparam int IX_DN     = 2;
    localparam int IX_DOPEN  = 1;
    localparam int IX_DSHUT  = 0;

endpackage

// File: rtl/bay_sync.sv
module bay_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] stg_d;
        if (i == 0) begin : g_first
            always_comb stg_d = din;
        end else begin : g_rest
            always_comb stg_d = stg_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/bay_seq.sv
module bay_seq
    import bay_door_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lever_s,
    input  logic     up_s,
    input  logic     dn_s,
    input  logic     dopen_s,
    input  logic     dshut_s,
    output door_st_e door_st,
    output logic     open_cmd,
    output logic     close_cmd,
    output logic     ext_cmd,
    output logic     ret_cmd
);
    typedef struct packed {
        door_st_e door;
        phase_e   phase;
        logic     tgt_ext;
        logic     open_cmd;
        logic     close_cmd;
        logic     ext_cmd;
        logic     ret_cmd;
    } seq_t;

    seq_t     q, d;
    door_st_e door_nxt;
    logic     gear_lk;
    logic     at_tgt;
    logic     tgt_hit;

    always_comb begin
        gear_lk = up_s | dn_s;
        at_tgt  = lever_s ? dn_s : up_s;
        tgt_hit = q.tgt_ext ? dn_s : up_s;

        door_nxt = q.door;
        case (q.door)
            DS_UNKNOWN: begin
                if (dopen_s)      door_nxt = DS_OPEN;
                else if (dshut_s) door_nxt = DS_SHUT;
            end
            DS_OPENING: if (dopen_s) door_nxt = DS_OPEN;
            DS_CLOSING: if (dshut_s) door_nxt = DS_SHUT;
            default:    door_nxt = q.door;
        endcase

        d      = q;
        d.door = door_nxt;
        case (q.phase)
            PH_IDLE: begin
                if (q.door != DS_UNKNOWN && gear_lk) begin
                    if (!at_tgt && (q.door == DS_SHUT || q.door == DS_OPEN)) begin
                        d.open_cmd = 1'b1;
                        d.tgt_ext  = lever_s;
                        d.phase    = PH_OPEN;
                        if (door_nxt != DS_OPEN) d.door = DS_OPENING;
                    end else if (at_tgt && q.door == DS_OPEN) begin
                        d.close_cmd = 1'b1;
                        d.door      = DS_CLOSING;
                        d.phase     = PH_CLOSE;
                    end
                end
            end
            PH_OPEN: begin
                if (door_nxt == DS_OPEN && dopen_s) begin
                    d.open_cmd = 1'b0;
                    d.phase    = PH_MOVE;
                    d.ext_cmd  = q.tgt_ext;
                    d.ret_cmd  = !q.tgt_ext;
                end
            end
            PH_MOVE: begin
                if (tgt_hit) begin
                    d.ext_cmd   = 1'b0;
                    d.ret_cmd   = 1'b0;
                    d.close_cmd = 1'b1;
                    d.door      = DS_CLOSING;
                    d.phase     = PH_CLOSE;
                end else begin
                    d.ext_cmd = q.tgt_ext & dopen_s;
                    d.ret_cmd = !q.tgt_ext & dopen_s;
                end
            end
            default: begin
                if (door_nxt == DS_SHUT) begin
                    d.close_cmd = 1'b0;
                    d.phase     = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{door: DS_UNKNOWN, phase: PH_IDLE, tgt_ext: 1'b0,
                   open_cmd: 1'b0, close_cmd: 1'b0, ext_cmd: 1'b0, ret_cmd: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign door_st   = q.door;
    assign open_cmd  = q.open_cmd;
    assign close_cmd = q.close_cmd;
    assign ext_cmd   = q.ext_cmd;
    assign ret_cmd   = q.ret_cmd;

    a_r4_gear_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ext_cmd || q.ret_cmd) |-> (q.door == DS_OPEN));
    a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.ext_cmd, q.ret_cmd}));
    a_r6_close_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.close_cmd) |-> $past(gear_lk));
    a_r6_open_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.open_cmd) |-> $past(gear_lk));
    a_r1_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.door == DS_UNKNOWN) |-> !(q.open_cmd || q.close_cmd || q.ext_cmd || q.ret_cmd));
endmodule

// File: rtl/bay_fault.sv
module bay_fault
    import bay_door_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     up_s,
    input  logic     dn_s,
    input  logic     dopen_s,
    input  door_st_e door_st,
    output logic     fault
);
    logic fault_d, fault_q;
    logic armed, door_safe;

    always_comb begin
        armed     = (door_st != DS_UNKNOWN);
        door_safe = (door_st == DS_OPEN) && dopen_s;
        fault_d   = fault_q | (armed && !(up_s || dn_s) && !door_safe);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_d;
    end

    assign fault = fault_q;

    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |=> fault_q);
endmodule

// File: rtl/bay_door_ctrl.sv
module bay_door_ctrl
    import bay_door_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lever_ext,
    input  logic       gear_up_lk,
    input  logic       gear_dn_lk,
    input  logic       door_open_lk,
    input  logic       door_shut_lk,
    output logic       door_open_cmd,
    output logic       door_close_cmd,
    output logic       gear_ext_cmd,
    output logic       gear_ret_cmd,
    output logic [2:0] door_state,
    output logic       fault
);
    logic [SENSE_W-1:0] raw, syn;
    door_st_e           door_st;

    assign raw[IX_LEVER] = lever_ext;
    assign raw[IX_UP]    = gear_up_lk;
    assign raw[IX_DN]    = gear_dn_lk;
    assign raw[IX_DOPEN] = door_open_lk;
    assign raw[IX_DSHUT] = door_shut_lk;

    bay_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw), .dout(syn)
    );

    bay_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .lever_s(syn[IX_LEVER]), .up_s(syn[IX_UP]), .dn_s(syn[IX_DN]),
        .dopen_s(syn[IX_DOPEN]), .dshut_s(syn[IX_DSHUT]),
        .door_st(door_st),
        .open_cmd(door_open_cmd), .close_cmd(door_close_cmd),
        .ext_cmd(gear_ext_cmd), .ret_cmd(gear_ret_cmd)
    );

    bay_fault u_fault (
        .clk(clk), .rst_n(rst_n),
        .up_s(syn[IX_UP]), .dn_s(syn[IX_DN]), .dopen_s(syn[IX_DOPEN]),
        .door_st(door_st), .fault(fault)
    );

    assign door_state = door_st;

    a_r1_no_motion_unresolved: assert property (@(posedge clk) disable iff (!rst_n)
        (door_state == 3'd0) |-> !(gear_ext_cmd || gear_ret_cmd));
endmodule

// File: tb/sim_bay_door_ctrl.sv
module sim_bay_door_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lever_ext = 1'b0, gear_up_lk = 1'b1, gear_dn_lk = 1'b0;
    logic door_open_lk = 1'b0, door_shut_lk = 1'b0;
    logic door_open_cmd, door_close_cmd, gear_ext_cmd, gear_ret_cmd, fault;
    logic [2:0] door_state;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    bay_door_ctrl u0 (.*);

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int st, input int op, input int cl,
                           input int ex, input int rt);
        chk(req, "door_state", int'(door_state), st);
        chk(req, "door_open_cmd", int'(door_open_cmd), op);
        chk(req, "door_close_cmd", int'(door_close_cmd), cl);
        chk(req, "gear_ext_cmd", int'(gear_ext_cmd), ex);
        chk(req, "gear_ret_cmd", int'(gear_ret_cmd), rt);
    endtask

    // one stroke toward ext; pre = open command already pending; flip = lever moved mid-stroke
    task automatic stroke(input logic ext, input logic flip, input logic pre);
        int e = int'(ext);
        int r = int'(!ext);
        if (!pre) begin
            lever_ext = ext;
            step(2);
            chk("R9", "open before third edge", int'(door_open_cmd), 0);
            step(1);
        end
        chk_all("R3", 2, 1, 0, 0, 0);
        step(5);
        chk_all("R4 wait open lock", 2, 1, 0, 0, 0);
        door_shut_lk = 1'b0;
        door_open_lk = 1'b1;
        step(2);
        chk("R9", "gear cmd before third edge", int'(gear_ext_cmd | gear_ret_cmd), 0);
        step(1);
        chk_all("R4", 3, 0, 0, e, r);
        if (ext) gear_up_lk = 1'b0; else gear_dn_lk = 1'b0;
        step(3);
        chk_all("R6 no door cmd moving", 3, 0, 0, e, r);
        chk("R8", "fault while moving open", int'(fault), 0);
        if (flip) begin
            lever_ext = !ext;
            step(6);
            chk_all("R7 no reversal", 3, 0, 0, e, r);
        end
        if (ext) gear_dn_lk = 1'b1; else gear_up_lk = 1'b1;
        step(3);
        chk_all("R5", 4, 0, 1, 0, 0);
        door_open_lk = 1'b0;
        step(3);
        chk_all("R5 close held", 4, 0, 1, 0, 0);
        chk("R8", "fault while closing", int'(fault), 0);
        door_shut_lk = 1'b1;
        step(3);
        chk_all("R5 closed", 1, 0, 0, 0, 0);
        if (flip) begin
            step(1);
            chk_all("R7 pending serviced", 2, 1, 0, 0, 0);
        end
    endtask

    task automatic run();
        step(3);
        rst_n = 1'b1;
        chk_all("R1 reset", 0, 0, 0, 0, 0);
        chk("R1", "fault at reset", int'(fault), 0);
        lever_ext = 1'b1;
        step(10);
        chk_all("R1 lever ignored unknown", 0, 0, 0, 0, 0);
        chk("R1", "fault unknown", int'(fault), 0);
        lever_ext = 1'b0;
        step(4);
        door_shut_lk = 1'b1;
        step(2);
        chk("R9", "state before third edge", int'(door_state), 0);
        step(1);
        chk_all("R2 resolved shut", 1, 0, 0, 0, 0);
        step(4);
        chk_all("R2 idle at target", 1, 0, 0, 0, 0);

        stroke(1'b1, 1'b0, 1'b0);
        stroke(1'b0, 1'b0, 1'b0);
        stroke(1'b1, 1'b1, 1'b0);
        stroke(1'b0, 1'b1, 1'b1);
        stroke(1'b1, 1'b0, 1'b1);
        stroke(1'b0, 1'b0, 1'b0);

        // fault: gear out of both locks, door shut
        gear_up_lk = 1'b0;
        step(2);
        chk("R9", "fault before third edge", int'(fault), 0);
        step(1);
        chk("R8", "fault set", int'(fault), 1);
        step(3);
        chk_all("R6 no door cmd unlocked", 1, 0, 0, 0, 0);
        gear_up_lk = 1'b1;
        step(20);
        chk("R8", "fault sticky", int'(fault), 1);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R8", "fault cleared by reset", int'(fault), 0);
        chk_all("R1 second reset", 0, 0, 0, 0, 0);
        step(4);
        chk_all("R2 resolved again", 1, 0, 0, 0, 0);

        // resolve to locked open from unknown, then idle close at target
        rst_n = 1'b0;
        door_shut_lk = 1'b0;
        door_open_lk = 1'b1;
        step(2);
        rst_n = 1'b1;
        step(3);
        chk_all("R2 resolved open", 3, 0, 0, 0, 0);
        step(1);
        chk_all("R5 idle close from open", 4, 0, 1, 0, 0);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule